// File: doc/BRIEF.md
# Thread-Aware Branch Target Buffer

This block predicts the target of taken branches for a fetch unit that runs several hardware threads. It is a single direct-mapped table with a power-of-two number of slots. Each slot holds a valid flag, a partial address tag, the number of the thread that wrote it and a predicted target address. The fetch stage presents a PC and a thread number on the lookup side. In the same cycle it receives a hit flag and, on a hit, the stored target. A branch that resolves later writes its PC, thread and target through the update side. The write lands at the next clock edge.

All threads share one table. To spread their working sets, the thread number is folded by XOR into the most significant bits of the slot index. The thread number is also kept in each slot and compared on lookup, so one thread can never consume another thread's prediction. An asynchronous active-low reset and a synchronous flush input both empty the table by clearing every valid flag.

Top module: `thread_btb`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every lookup misses and returns a target of zero.
- R2: The slot index is ((PC >> INST_SHIFT) XOR (thread << (IDX_W - log2 THREADS))) mod ENTRIES. With the default sizes, one PC written by two different threads occupies two slots, and each thread reads back its own target.
- R3: The stored and compared tag is PC bits [INST_SHIFT+IDX_W +: TAG_W]. A lookup whose PC differs from a written PC in the lowest tag bit misses.
- R4: A lookup hits only if the indexed slot is valid, its tag equals the lookup tag, and its thread equals the lookup thread. A lookup that reaches a written slot with a matching tag from a different thread misses.
- R5: On a miss the target output is all zeros.
- R6: An update strobe writes the indexed slot at the next rising edge without regard to its previous contents. It sets valid and stores tag, thread and target, and a following lookup with the same PC and thread hits with that target.
- R7: A lookup in the same cycle as an update to the same slot returns the contents from before the update.
- R8: A flush clears every valid flag at the next edge. When a flush and an update arrive in the same cycle, the flush wins and the slot stays invalid.
- R9: PC bits above the tag field do not take part in the lookup, so a PC that differs from a written PC only in those bits hits and returns the written target.
- R10: PC bits below INST_SHIFT do not take part in the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Empties the whole table at the next edge |
| lk_pc_i | input | PC_W | Fetch PC to look up |
| lk_tid_i | input | TID_W | Thread issuing the lookup (TID_W = max(1, log2 THREADS)) |
| lk_hit_o | output | 1 | Lookup hit |
| lk_target_o | output | PC_W | Predicted target on a hit, zero otherwise |
| up_valid_i | input | 1 | Update strobe |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_tid_i | input | TID_W | Thread of the resolved branch |
| up_target_i | input | PC_W | Resolved target to store |

## Verification
The bench aims at PC pairs that reach the same slot from different threads through the XOR fold. It also covers pairs that differ only in the lowest tag bit, only above the tag field, or only in the offset bits. A design that dropped the thread compare would hand one thread another's target. A design with a misplaced tag field would either miss on aliases that should hit or hit on neighbours that should miss. Same-cycle update and lookup to one slot exposes a write-through read path, which would show the new target a cycle early. A flush arriving together with an update exposes the wrong priority, which leaves a valid slot after the flush.

// File: rtl/thread_btb_pkg.sv
package thread_btb_pkg;

  // Number of index bits needed for n items; a single item needs none.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

endpackage

// File: rtl/thread_btb_hash.sv
// Derives slot index and partial tag from a PC and a thread number.
module thread_btb_hash #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 16,
  parameter int INST_SHIFT = 2,
  parameter int TID_W      = 2,
  parameter int TID_LOG    = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [TID_W-1:0] tid_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);

  localparam int TID_SHIFT = IDX_W - TID_LOG;
  localparam int TAG_LSB   = INST_SHIFT + IDX_W;

  logic [IDX_W-1:0] pc_slot;
  logic [IDX_W-1:0] tid_spread;

  assign pc_slot = IDX_W'(pc_i >> INST_SHIFT);

  generate
    if (TID_LOG == 0) begin : g_one_thread
      assign tid_spread = '0;
    end else begin : g_multi_thread
      logic [IDX_W-1:0] tid_ext;
      assign tid_ext    = IDX_W'(tid_i);
      assign tid_spread = tid_ext << TID_SHIFT;
    end
  endgenerate

  assign idx_o = pc_slot ^ tid_spread;
  assign tag_o = TAG_W'(pc_i >> TAG_LSB);

  // Offset and high PC bits are intentionally dropped.
  logic unused_hash;
  assign unused_hash = ^{pc_i, tid_i};

endmodule

// File: rtl/thread_btb_store.sv
// Slot storage: resettable valid flags, enable-written payload flops.
module thread_btb_store #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 16,
  parameter int TID_W   = 2,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [TID_W-1:0]   wr_tid_i,
  input  logic [PC_W-1:0]    wr_tgt_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [TID_W-1:0]   rd_tid_o,
  output logic [PC_W-1:0]    rd_tgt_o,
  output logic [ENTRIES-1:0] ent_we_o
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic [TID_W-1:0]   tid_arr [ENTRIES];
  logic [PC_W-1:0]    tgt_arr [ENTRIES];

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic             vld_r;
      logic             vld_d;
      logic [TAG_W-1:0] tag_r;
      logic [TID_W-1:0] tid_r;
      logic [PC_W-1:0]  tgt_r;

      // Flush has priority over a write in the same cycle.
      assign ent_we_o[e] = wr_en_i && !flush_i && (wr_idx_i == IDX_W'(e));

      always_comb begin
        vld_d = vld_r;
        if (flush_i) begin
          vld_d = 1'b0;
        end else if (ent_we_o[e]) begin
          vld_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_r <= 1'b0;
        end else begin
          vld_r <= vld_d;
        end
      end

      always_ff @(posedge clk) begin
        if (ent_we_o[e]) begin
          tag_r <= wr_tag_i;
          tid_r <= wr_tid_i;
          tgt_r <= wr_tgt_i;
        end
      end

      assign vld_q[e]   = vld_r;
      assign tag_arr[e] = tag_r;
      assign tid_arr[e] = tid_r;
      assign tgt_arr[e] = tgt_r;
    end
  endgenerate

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_tag_o   = tag_arr[rd_idx_i];
  assign rd_tid_o   = tid_arr[rd_idx_i];
  assign rd_tgt_o   = tgt_arr[rd_idx_i];

endmodule

// File: rtl/thread_btb_match.sv
// Qualifies the indexed slot against the requesting tag and thread.
module thread_btb_match #(
  parameter int TAG_W   = 16,
  parameter int TID_W   = 2,
  parameter int PC_W    = 32,
  parameter int TID_LOG = 2
) (
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [TID_W-1:0] ent_tid_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [TID_W-1:0] req_tid_i,
  output logic             hit_o,
  output logic [PC_W-1:0]  tgt_o
);

  logic tid_ok;

  generate
    if (TID_LOG == 0) begin : g_tid_free
      logic unused_tid;
      assign unused_tid = ^{ent_tid_i, req_tid_i};
      assign tid_ok     = 1'b1;
    end else begin : g_tid_cmp
      assign tid_ok = (ent_tid_i == req_tid_i);
    end
  endgenerate

  assign hit_o = ent_valid_i && (ent_tag_i == req_tag_i) && tid_ok;
  assign tgt_o = hit_o ? ent_tgt_i : '0;

endmodule

// File: rtl/thread_btb.sv
// Direct-mapped, thread-tagged branch target buffer.
module thread_btb #(
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 64,
  parameter int TAG_W      = 16,
  parameter int INST_SHIFT = 2,
  parameter int THREADS    = 4,
  localparam int TID_LOG   = thread_btb_pkg::bits_for(THREADS),
  localparam int TID_W     = (TID_LOG == 0) ? 1 : TID_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [TID_W-1:0] lk_tid_i,
  output logic             lk_hit_o,
  output logic [PC_W-1:0]  lk_target_o,
  input  logic             up_valid_i,
  input  logic [PC_W-1:0]  up_pc_i,
  input  logic [TID_W-1:0] up_tid_i,
  input  logic [PC_W-1:0]  up_target_i
);

  localparam int IDX_W = thread_btb_pkg::bits_for(ENTRIES);

  logic [IDX_W-1:0]   lk_idx;
  logic [TAG_W-1:0]   lk_tag;
  logic [IDX_W-1:0]   up_idx;
  logic [TAG_W-1:0]   up_tag;
  logic               slot_valid;
  logic [TAG_W-1:0]   slot_tag;
  logic [TID_W-1:0]   slot_tid;
  logic [PC_W-1:0]    slot_tgt;
  logic [ENTRIES-1:0] ent_we;

  thread_btb_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .INST_SHIFT(INST_SHIFT),
    .TID_W(TID_W), .TID_LOG(TID_LOG)
  ) u_hash_lk (
    .pc_i (lk_pc_i),
    .tid_i(lk_tid_i),
    .idx_o(lk_idx),
    .tag_o(lk_tag)
  );

  thread_btb_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .INST_SHIFT(INST_SHIFT),
    .TID_W(TID_W), .TID_LOG(TID_LOG)
  ) u_hash_up (
    .pc_i (up_pc_i),
    .tid_i(up_tid_i),
    .idx_o(up_idx),
    .tag_o(up_tag)
  );

  thread_btb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W), .PC_W(PC_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .wr_en_i   (up_valid_i),
    .wr_idx_i  (up_idx),
    .wr_tag_i  (up_tag),
    .wr_tid_i  (up_tid_i),
    .wr_tgt_i  (up_target_i),
    .rd_idx_i  (lk_idx),
    .rd_valid_o(slot_valid),
    .rd_tag_o  (slot_tag),
    .rd_tid_o  (slot_tid),
    .rd_tgt_o  (slot_tgt),
    .ent_we_o  (ent_we)
  );

  thread_btb_match #(
    .TAG_W(TAG_W), .TID_W(TID_W), .PC_W(PC_W), .TID_LOG(TID_LOG)
  ) u_match (
    .ent_valid_i(slot_valid),
    .ent_tag_i  (slot_tag),
    .ent_tid_i  (slot_tid),
    .ent_tgt_i  (slot_tgt),
    .req_tag_i  (lk_tag),
    .req_tid_i  (lk_tid_i),
    .hit_o      (lk_hit_o),
    .tgt_o      (lk_target_o)
  );

endmodule

// File: rtl/thread_btb_chk.sv
module thread_btb_chk #(
  parameter int PC_W    = 32,
  parameter int TID_W   = 2,
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic [PC_W-1:0]    lk_pc_i,
  input logic [TID_W-1:0]   lk_tid_i,
  input logic               lk_hit_o,
  input logic [PC_W-1:0]    lk_target_o,
  input logic               up_valid_i,
  input logic [PC_W-1:0]    up_pc_i,
  input logic [TID_W-1:0]   up_tid_i,
  input logic [PC_W-1:0]    up_target_i,
  input logic [ENTRIES-1:0] ent_we
);

  // R1: the table reads empty while reset is held
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |-> (!lk_hit_o && lk_target_o == '0));

  // R6: at most one slot is written per cycle
  p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_we));

  // R6: a written PC/thread pair reads back its target on the next cycle
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_i && !flush_i) |=>
      (((lk_pc_i == $past(up_pc_i)) && (lk_tid_i == $past(up_tid_i))) ->
        (lk_hit_o && lk_target_o == $past(up_target_i))));

  // R6: without a write or flush the table contents do not move
  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_valid_i && !flush_i) |=>
      (($stable(lk_pc_i) && $stable(lk_tid_i)) ->
        ($stable(lk_hit_o) && $stable(lk_target_o))));

  // R8: after a flush every lookup misses
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lk_hit_o);

endmodule

bind thread_btb thread_btb_chk #(
  .PC_W(PC_W), .TID_W(TID_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .lk_pc_i    (lk_pc_i),
  .lk_tid_i   (lk_tid_i),
  .lk_hit_o   (lk_hit_o),
  .lk_target_o(lk_target_o),
  .up_valid_i (up_valid_i),
  .up_pc_i    (up_pc_i),
  .up_tid_i   (up_tid_i),
  .up_target_i(up_target_i),
  .ent_we     (ent_we)
);

// File: tb/thread_btb_tb_top.sv
`timescale 1ns/1ps
module thread_btb_tb_top;

  localparam int PC_W    = 32;
  localparam int ENT     = 64;
  localparam int TAG_W   = 16;
  localparam int SH      = 2;
  localparam int THR     = 4;
  localparam int IDX_W   = 6;
  localparam int TID_W   = 2;
  localparam int TID_SH  = IDX_W - 2;
  localparam int TAG_LSB = SH + IDX_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush_i;
  logic [PC_W-1:0]  lk_pc_i;
  logic [TID_W-1:0] lk_tid_i;
  logic             lk_hit_o;
  logic [PC_W-1:0]  lk_target_o;
  logic             up_valid_i;
  logic [PC_W-1:0]  up_pc_i;
  logic [TID_W-1:0] up_tid_i;
  logic [PC_W-1:0]  up_target_i;

  always #4 clk = ~clk;

  thread_btb #(
    .PC_W(PC_W), .ENTRIES(ENT), .TAG_W(TAG_W), .INST_SHIFT(SH), .THREADS(THR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_pc_i(lk_pc_i), .lk_tid_i(lk_tid_i),
    .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
    .up_valid_i(up_valid_i), .up_pc_i(up_pc_i),
    .up_tid_i(up_tid_i), .up_target_i(up_target_i)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit               m_v   [ENT];
  logic [TAG_W-1:0] m_tag [ENT];
  logic [TID_W-1:0] m_tid [ENT];
  logic [PC_W-1:0]  m_tgt [ENT];

  function automatic int ref_idx(input logic [PC_W-1:0] pc, input logic [TID_W-1:0] tid);
    return int'(((pc >> SH) ^ (32'(tid) << TID_SH)) & (ENT - 1));
  endfunction

  function automatic logic [TAG_W-1:0] ref_tag(input logic [PC_W-1:0] pc);
    return TAG_W'(pc >> TAG_LSB);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
  endtask

  task automatic check(input string req, input logic e_hit, input logic [PC_W-1:0] e_tgt);
    n_vec++;
    if (lk_hit_o !== e_hit || lk_target_o !== e_tgt) begin
      n_bad++;
      $display("FAIL %s: pc=%h tid=%0d got hit=%b target=%h, expected hit=%b target=%h",
               req, lk_pc_i, lk_tid_i, lk_hit_o, lk_target_o, e_hit, e_tgt);
    end
  endtask

  // One cycle: drive between edges, compare against the model as it stands
  // before this cycle's write, then commit the write/flush into the model.
  task automatic step(input logic [PC_W-1:0] lpc, input logic [TID_W-1:0] ltid,
                      input bit uv, input logic [PC_W-1:0] upc,
                      input logic [TID_W-1:0] utid, input logic [PC_W-1:0] utgt,
                      input bit fl, input string req);
    int       ix;
    logic     e_hit;
    @(negedge clk);
    lk_pc_i = lpc; lk_tid_i = ltid;
    up_valid_i = uv; up_pc_i = upc; up_tid_i = utid; up_target_i = utgt;
    flush_i = fl;
    #1;
    ix    = ref_idx(lpc, ltid);
    e_hit = m_v[ix] && (m_tag[ix] == ref_tag(lpc)) && (m_tid[ix] == ltid);
    check(req, e_hit, e_hit ? m_tgt[ix] : '0);
    if (fl) begin
      model_clear();
    end else if (uv) begin
      ix = ref_idx(upc, utid);
      m_v[ix] = 1'b1; m_tag[ix] = ref_tag(upc); m_tid[ix] = utid; m_tgt[ix] = utgt;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] lpc, input logic [TID_W-1:0] ltid, input string req);
    step(lpc, ltid, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic write(input logic [PC_W-1:0] upc, input logic [TID_W-1:0] utid,
                       input logic [PC_W-1:0] utgt);
    step(upc ^ 32'h0000_1000, utid, 1'b1, upc, utid, utgt, 1'b0, "R6");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R6: watchdog expired after %0d vectors, expected completion", n_vec);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  logic [PC_W-1:0] pool [8];
  localparam logic [PC_W-1:0] A = 32'h0012_3450;

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h0000_5EED);
    rst_n = 1'b1; flush_i = 1'b0;
    lk_pc_i = '0; lk_tid_i = '0;
    up_valid_i = 1'b0; up_pc_i = '0; up_tid_i = '0; up_target_i = '0;
    model_clear();
    #1 rst_n = 1'b0;

    // R1: outputs empty while reset is held
    repeat (2) @(negedge clk);
    lk_pc_i = A; lk_tid_i = 2'd0; #1; check("R1", 1'b0, '0);
    lk_pc_i = 32'hFFFF_FFFC; lk_tid_i = 2'd3; #1; check("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;
    look(A, 2'd0, "R1");
    look(32'h8000_0000, 2'd2, "R1");

    // R7: same-cycle write and lookup to one slot sees old contents
    step(A, 2'd0, 1'b1, A, 2'd0, 32'hAAAA_0001, 1'b0, "R7");
    look(A, 2'd0, "R6");
    // R4: same slot and tag reached from another thread misses
    look(A ^ 32'h0000_0040, 2'd1, "R4");
    // R3: lowest tag bit differs
    look(A ^ (32'h1 << TAG_LSB), 2'd0, "R3");
    // R9: bits above the tag field ignored
    look(A ^ 32'h8000_0000, 2'd0, "R9");
    look(A ^ 32'h0100_0000, 2'd0, "R9");
    // R10: offset bits ignored
    look(A | 32'h3, 2'd0, "R10");
    // R2: same PC from two threads lands in two slots
    write(A, 2'd1, 32'hBBBB_0002);
    look(A, 2'd0, "R2");
    look(A, 2'd1, "R2");
    // R6: overwrite without regard to previous contents
    write(A, 2'd0, 32'hCCCC_0003);
    look(A, 2'd0, "R6");
    // R5: miss target is zero
    look(32'h0ABC_DEF0, 2'd3, "R5");
    // R8: flush together with a write, flush wins
    step(A, 2'd0, 1'b1, A, 2'd2, 32'hDDDD_0004, 1'b1, "R8");
    look(A, 2'd0, "R8");
    look(A, 2'd1, "R8");
    look(A, 2'd2, "R8");

    // Random phase
    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0]  lpc;
      logic [PC_W-1:0]  upc;
      int unsigned      r;
      lpc = pool[$urandom_range(0, 7)];
      r   = $urandom_range(0, 9);
      case (r)
        0: lpc = lpc ^ (32'h1 << TAG_LSB);
        1: lpc = $urandom;
        2: lpc = lpc ^ 32'hC000_0000;
        3: lpc = lpc ^ 32'($urandom_range(0, 3));
        4: lpc = lpc ^ (32'h1 << (SH + TID_SH));
        default: ;
      endcase
      upc = pool[$urandom_range(0, 7)];
      step(lpc, TID_W'($urandom_range(0, 3)),
           ($urandom_range(0, 9) < 4), upc, TID_W'($urandom_range(0, 3)), $urandom,
           ($urandom_range(0, 199) == 0), "R2 R3 R4 R5 R6");
    end

    // R1: reset in the middle of operation empties the table
    @(negedge clk);
    up_valid_i = 1'b0; flush_i = 1'b0;
    rst_n = 1'b0; model_clear();
    lk_pc_i = pool[0]; lk_tid_i = 2'd0; #1; check("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) look(pool[i], TID_W'(i), "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule